// File: doc/BRIEF.md
# Edge-Triggered Port Interrupt Controller

This block watches an eight-pin input port and turns chosen signal edges into interrupt requests. Each pin carries three control bits held in three byte-wide registers: an edge-sense bit that picks whether a falling (0) or a rising (1) transition is of interest, a mask bit that lets that pin reach the request line, and a sticky event bit that records a detected edge until software clears it. The pins are asynchronous, so they pass through a two-stage synchronizer before a history flop compares each pin's current and previous sampled level.

The same edge-sense bit also selects the pin's weak pull device. A pin watching for falling edges rests high through a pull-up, and a pin watching for rising edges rests low through a pull-down. Either pull is applied only when the pull-enable input for that pin is set and the pin is not driven as an output. A small synchronous register bus gives read and write access to the three registers. The single request output is the OR of every event bit that is also unmasked.

Top module: `port_edge_irq`

## Requirements
- R1: After a synchronous reset the edge-sense, mask and event registers read 0x00, and `irq_o`, `pull_up_o` and `pull_dn_o` are all 0.
- R2: With a pin's edge-sense bit at 0, a falling level on that pin sets its event bit, and a rising level does not. A pin changed just after a clock edge shows its event bit, and `irq_o` if unmasked, after the third following rising clock edge and not after the second.
- R3: With a pin's edge-sense bit at 1, a rising level on that pin sets its event bit, and a falling level does not.
- R4: `irq_o` is 1 exactly when some pin has both its event bit and its mask bit at 1. Clearing a mask bit removes that pin from `irq_o` in the same cycle without changing the event bit.
- R5: Writing the event register (address 2) clears each event bit written with 1 and leaves each bit written with 0 unchanged.
- R6: When a new edge and a clearing write hit the same event bit on the same clock edge, the bit ends up set.
- R7: Writing a new edge-sense value while all pins are steady sets no event bit.
- R8: For each pin, `pull_up_o` is 1 when its pull enable is 1, it is not an output and its edge-sense bit is 0. `pull_dn_o` is 1 under the same conditions with the edge-sense bit at 1. Both are registered and follow their inputs one clock edge later. They are never both 1.
- R9: No edge is detected until three clock edges after reset ends. A pin held at a steady level through reset never sets an event bit, even when its edge-sense bit is written right away.
- R10: Register addresses: 0 selects edge sense, 1 selects mask, 2 selects event bits, and 3 reads 0x00 and ignores writes. Read data appears on `bus_rdata_o` one clock edge after a read is presented.
- R11: An event bit, once set, stays set over any number of cycles until a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous port pin levels |
| pull_en_i | input | 8 | Per-pin pull enable |
| dir_out_i | input | 8 | Per-pin direction, 1 = driven as output |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| pull_up_o | output | 8 | Per-pin pull-up enable |
| pull_dn_o | output | 8 | Per-pin pull-down enable |

## Verification
A pin change takes three rising edges to reach an event bit: one through each synchronizer stage and one into the event register. The bench therefore changes pins just after a falling edge and samples `irq_o` at the falling edges after the second and the third rising edge, expecting the request at the third and not at the second. Register writes and reads each settle on the next rising edge, pull outputs follow one rising edge after their inputs, and all samples are taken at falling edges. The same-edge set-versus-clear case is built by placing the clearing write exactly on the third rising edge after a pin change.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE = 2'd0,
    REG_MASK  = 2'd1,
    REG_EVENT = 2'd2,
    REG_SPARE = 2'd3
  } reg_sel_e;

  localparam int ARM_CYCLES = 3;
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pei_edge.sv
module pei_edge #(
  parameter int WIDTH = 8,
  parameter int ARM   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] sense_i,
  output logic [WIDTH-1:0] hit_o
);
  localparam int CNT_W = $clog2(ARM + 1);

  logic [WIDTH-1:0] hist_q;
  logic [CNT_W-1:0] arm_q;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      arm_q  <= '0;
    end else begin
      hist_q <= level_i;
      if (!armed) arm_q <= arm_q + 1'b1;
    end
  end

  assign armed = (arm_q == CNT_W'(ARM));

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic rise, fall;
    assign rise     = level_i[i] & ~hist_q[i];
    assign fall     = ~level_i[i] & hist_q[i];
    assign hit_o[i] = armed & (sense_i[i] ? rise : fall);
  end
endmodule

// File: rtl/pei_regs.sv
module pei_regs
  import pei_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  hit_i,
  output logic [WIDTH-1:0]  sense_o,
  output logic [WIDTH-1:0]  mask_o,
  output logic [WIDTH-1:0]  event_o
);
  reg_sel_e         sel_reg;
  logic             wr_en;
  logic [WIDTH-1:0] clr_bits;
  logic [WIDTH-1:0] rd_mux;

  assign sel_reg  = reg_sel_e'(addr_i);
  assign wr_en    = sel_i & wr_i;
  assign clr_bits = (wr_en && sel_reg == REG_EVENT) ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_o <= '0;
      mask_o  <= '0;
      event_o <= '0;
    end else begin
      if (wr_en && sel_reg == REG_SENSE) sense_o <= wdata_i;
      if (wr_en && sel_reg == REG_MASK)  mask_o  <= wdata_i;
      event_o <= (event_o & ~clr_bits) | hit_i;
    end
  end

  always_comb begin
    case (sel_reg)
      REG_SENSE: rd_mux = sense_o;
      REG_MASK:  rd_mux = mask_o;
      REG_EVENT: rd_mux = event_o;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                rdata_o <= '0;
    else if (sel_i && !wr_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/pei_pull.sv
module pei_pull #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sense_i,
  input  logic [WIDTH-1:0] pull_en_i,
  input  logic [WIDTH-1:0] dir_out_i,
  output logic [WIDTH-1:0] up_o,
  output logic [WIDTH-1:0] dn_o
);
  logic [WIDTH-1:0] active;
  assign active = pull_en_i & ~dir_out_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_o <= '0;
      dn_o <= '0;
    end else begin
      up_o <= active & ~sense_i;
      dn_o <= active & sense_i;
    end
  end
endmodule

// File: rtl/port_edge_irq.sv
module port_edge_irq
  import pei_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  pull_en_i,
  input  logic [NPINS-1:0]  dir_out_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic [NPINS-1:0]  pull_up_o,
  output logic [NPINS-1:0]  pull_dn_o
);
  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] hit;
  logic [NPINS-1:0] sense_q;
  logic [NPINS-1:0] mask_q;
  logic [NPINS-1:0] event_q;

  pei_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(pin_sync)
  );

  pei_edge #(.WIDTH(NPINS), .ARM(ARM_CYCLES)) u_edge (
    .clk(clk), .rst(rst), .level_i(pin_sync), .sense_i(sense_q), .hit_o(hit)
  );

  pei_regs #(.WIDTH(NPINS)) u_regs (
    .clk(clk), .rst(rst),
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .hit_i(hit), .sense_o(sense_q), .mask_o(mask_q), .event_o(event_q)
  );

  pei_pull #(.WIDTH(NPINS)) u_pull (
    .clk(clk), .rst(rst), .sense_i(sense_q), .pull_en_i(pull_en_i),
    .dir_out_i(dir_out_i), .up_o(pull_up_o), .dn_o(pull_dn_o)
  );

  assign irq_o = |(event_q & mask_q);
endmodule

// File: rtl/pei_chk.sv
module pei_chk
  import pei_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NPINS-1:0]  bus_wdata_i,
  input logic [NPINS-1:0]  pull_en_i,
  input logic [NPINS-1:0]  dir_out_i,
  input logic              irq_o,
  input logic [NPINS-1:0]  pull_up_o,
  input logic [NPINS-1:0]  pull_dn_o,
  input logic [NPINS-1:0]  sense_q,
  input logic [NPINS-1:0]  event_q
);
  logic             sense_wr;
  logic [NPINS-1:0] clr_mask;
  assign sense_wr = bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(REG_SENSE);
  assign clr_mask = (bus_sel_i && bus_wr_i && bus_addr_i == ADDR_W'(REG_EVENT))
                    ? bus_wdata_i : '0;

  // R8
  pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (pull_up_o & pull_dn_o) == '0);

  // R8
  pull_gate_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pull_up_o | pull_dn_o) & ($past(dir_out_i) | ~$past(pull_en_i))) == '0);

  // R4
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (event_q == '0) |-> !irq_o);

  // R11
  event_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($past(event_q) & ~event_q & ~$past(clr_mask)) == '0);

  // R10
  sense_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sense_wr |=> $stable(sense_q));
endmodule

bind port_edge_irq pei_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst),
  .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .pull_en_i(pull_en_i), .dir_out_i(dir_out_i),
  .irq_o(irq_o), .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o),
  .sense_q(sense_q), .event_q(event_q)
);

// File: tb/port_edge_irq_tb.sv
module port_edge_irq_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] pin_i = '0;
  logic [N-1:0] pull_en_i = '0;
  logic [N-1:0] dir_out_i = '0;
  logic         bus_sel_i = 1'b0;
  logic         bus_wr_i = 1'b0;
  logic [1:0]   bus_addr_i = '0;
  logic [N-1:0] bus_wdata_i = '0;
  logic [N-1:0] bus_rdata_o;
  logic         irq_o;
  logic [N-1:0] pull_up_o;
  logic [N-1:0] pull_dn_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  port_edge_irq #(.NPINS(N)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin_i), .pull_en_i(pull_en_i),
    .dir_out_i(dir_out_i), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
    .pull_up_o(pull_up_o), .pull_dn_o(pull_dn_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [N-1:0] pins);
    pin_i = pins;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
    @(negedge clk);
    d = bus_rdata_o;
    bus_sel_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [N-1:0] d;
    do_reset('0);
    check("R1 irq", irq_o, 0);
    check("R1 pull_up", pull_up_o, 0);
    check("R1 pull_dn", pull_dn_o, 0);
    bus_read(2'd0, d); check("R1 sense", d, 0);
    bus_read(2'd1, d); check("R1 mask", d, 0);
    bus_read(2'd2, d); check("R1 event", d, 0);
  endtask

  task automatic t_regmap;
    logic [N-1:0] d;
    bus_write(2'd0, 8'hA5);
    bus_write(2'd1, 8'h3C);
    bus_read(2'd0, d); check("R10 sense readback", d, 8'hA5);
    bus_read(2'd1, d); check("R10 mask readback", d, 8'h3C);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, d); check("R10 spare reads zero", d, 0);
    bus_read(2'd0, d); check("R10 spare write harmless", d, 8'hA5);
    bus_write(2'd0, 8'h00);
    bus_write(2'd1, 8'h00);
  endtask

  task automatic t_fall;
    logic [N-1:0] d;
    bus_write(2'd1, 8'h04);
    pin_i[2] = 1'b1;
    wait_cyc(4);
    bus_read(2'd2, d); check("R2 rise ignored at sense 0", d, 0);
    pin_i[2] = 1'b0;
    wait_cyc(2);
    check("R2 not yet after two edges", irq_o, 0);
    wait_cyc(1);
    check("R2 irq after third edge", irq_o, 1);
    bus_read(2'd2, d); check("R2 event bit", d, 8'h04);
  endtask

  task automatic t_mask_sticky;
    logic [N-1:0] d;
    wait_cyc(12);
    check("R11 irq still held", irq_o, 1);
    bus_write(2'd1, 8'h00);
    check("R4 masked irq", irq_o, 0);
    bus_read(2'd2, d); check("R4 event kept under mask", d, 8'h04);
    bus_write(2'd1, 8'h04);
    check("R4 unmasked irq", irq_o, 1);
  endtask

  task automatic t_w1c;
    logic [N-1:0] d;
    bus_write(2'd2, 8'hFB);
    bus_read(2'd2, d); check("R5 zero bits untouched", d, 8'h04);
    bus_write(2'd2, 8'h04);
    bus_read(2'd2, d); check("R5 cleared", d, 0);
    check("R5 irq drops", irq_o, 0);
  endtask

  task automatic t_rise;
    logic [N-1:0] d;
    bus_write(2'd0, 8'h08);
    pin_i[3] = 1'b1;
    wait_cyc(3);
    bus_read(2'd2, d); check("R3 rise sets", d, 8'h08);
    bus_write(2'd2, 8'hFF);
    pin_i[3] = 1'b0;
    wait_cyc(4);
    bus_read(2'd2, d); check("R3 fall ignored at sense 1", d, 0);
  endtask

  task automatic t_sense_change;
    logic [N-1:0] d;
    pin_i = 8'hF0;
    wait_cyc(5);
    bus_write(2'd2, 8'hFF);
    bus_write(2'd0, 8'hFF);
    wait_cyc(5);
    bus_read(2'd2, d); check("R7 no event on sense 1", d, 0);
    bus_write(2'd0, 8'h00);
    wait_cyc(5);
    bus_read(2'd2, d); check("R7 no event on sense 0", d, 0);
  endtask

  task automatic t_collision;
    logic [N-1:0] d;
    pin_i[0] = 1'b1; wait_cyc(4);
    pin_i[0] = 1'b0; wait_cyc(4);
    bus_read(2'd2, d); check("R6 setup event", d, 8'h01);
    pin_i[0] = 1'b1; wait_cyc(4);
    pin_i[0] = 1'b0;
    wait_cyc(2);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = 2'd2; bus_wdata_i = 8'h01;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
    bus_read(2'd2, d); check("R6 set wins over clear", d, 8'h01);
    bus_write(2'd2, 8'h01);
    bus_read(2'd2, d); check("R6 later clear", d, 0);
  endtask

  task automatic t_pull;
    bus_write(2'd0, 8'h0F);
    pull_en_i = 8'hFF; dir_out_i = 8'h03;
    @(negedge clk);
    check("R8 pull_up", pull_up_o, 8'hF0);
    check("R8 pull_dn", pull_dn_o, 8'h0C);
    pull_en_i = 8'h00;
    @(negedge clk);
    check("R8 pull off", pull_up_o | pull_dn_o, 0);
    pull_en_i = 8'hFF; dir_out_i = 8'hFF;
    @(negedge clk);
    check("R8 output pins no pull", pull_up_o | pull_dn_o, 0);
    pull_en_i = '0; dir_out_i = '0;
  endtask

  task automatic t_prime;
    logic [N-1:0] d;
    do_reset(8'hFF);
    bus_write(2'd0, 8'hFF);
    wait_cyc(6);
    bus_read(2'd2, d); check("R9 steady pins after reset", d, 0);
  endtask

  initial begin
    t_reset();
    t_regmap();
    t_fall();
    t_mask_sticky();
    t_w1c();
    t_rise();
    t_sense_change();
    t_collision();
    t_pull();
    t_prime();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule